// File: doc/BRIEF.md
# Slotted Acknowledgement Sequencer

This block decides when an acknowledgement frame may go out after a frame has been received in auto-acknowledge receive mode. A received frame qualifies only if it is a data frame or a MAC command frame and asks for an acknowledgement. After such a frame ends, the block counts out the receive-to-transmit turnaround of six symbol periods. Each symbol period lasts 16 µs. The length of the count is derived from a clock-frequency parameter.

With slotted operation enabled, the block does not transmit on its own when the turnaround ends. It parks in a state the host can see, and the status output shows a success-and-waiting code. The block stays there until the host writes a trigger, which lets software place the acknowledgement on a slot boundary. A fixed delay of one symbol period after the trigger, it pulses the transmit-start strobe. With slotted operation disabled, the strobe fires by itself at the end of the turnaround. All pins are plain control and status levels or pulses. No data stream crosses the block's edge, so it has no valid/ready handshake.

Top module: `slotted_ack_seq`

## Requirements
- R1: After reset, `ack_status` is 0 (cleared) and `ack_tx_start` is 0.
- R2: A sequence starts only on an `rx_end` pulse whose `rx_ftype` is 1 (data) or 3 (MAC command) and whose `rx_ack_req` is 1. Any other type, or a clear request flag, causes no strobe and leaves `ack_status` unchanged.
- R3: With `slotted_en` high at the end pulse, `ack_status` becomes 2 (success, waiting for trigger) exactly READY_SYMBOLS×SYMBOL_US×CLK_MHZ clock edges after the edge that sampled `rx_end`.
- R4: While waiting, no strobe is issued until `host_trig` is seen, and `ack_status` holds 2.
- R5: A `host_trig` pulse sampled while waiting raises `ack_tx_start` exactly TRIG_DELAY_US×CLK_MHZ edges later. The strobe lasts one cycle.
- R6: Whenever the strobe fires, `ack_status` shows 1 (success) and the block returns to idle.
- R7: A `host_trig` pulse seen while idle or during the turnaround is ignored. It causes no strobe and does not shorten the wait.
- R8: With `slotted_en` low at the end pulse, the strobe fires on its own at the turnaround point, with `ack_status` 1 and code 2 never shown.
- R9: An `rx_end` pulse that arrives while a sequence is already active is ignored. The slotted choice is taken when the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slotted_en | input | 1 | Slotted operation enable |
| rx_end | input | 1 | One-cycle pulse at the last received symbol |
| rx_ftype | input | 3 | Frame type of the received frame |
| rx_ack_req | input | 1 | Received frame requests acknowledgement |
| host_trig | input | 1 | Host trigger write pulse |
| ack_status | output | 3 | 0 cleared, 1 success, 2 success waiting for trigger |
| ack_tx_start | output | 1 | One-cycle acknowledgement transmit-start strobe |

## Verification
The assertions check the following on every cycle:
- the strobe is one cycle wide and always comes with the success code;
- the waiting state always shows code 2 and holds without a trigger;
- a trigger in idle never moves the block;
- the timer is never restarted while it runs.

Only the bench scenarios can show the exact turnaround and trigger delays in clock edges. The same holds for frame qualification by type and request flag, for an early trigger being dropped, for a second end pulse being ignored mid-sequence, and for a reset during the wait clearing the status.

// File: rtl/ackseq_pkg.sv
package ackseq_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_TURN  = 2'd1,
    S_WAIT  = 2'd2,
    S_DELAY = 2'd3
  } seq_state_e;

  localparam logic [2:0] ST_NONE      = 3'd0;
  localparam logic [2:0] ST_SUCCESS   = 3'd1;
  localparam logic [2:0] ST_SUCC_WAIT = 3'd2;

  localparam logic [2:0] FT_DATA = 3'd1;
  localparam logic [2:0] FT_CMD  = 3'd3;

endpackage

// File: rtl/ackseq_qualify.sv
module ackseq_qualify
  import ackseq_pkg::*;
(
  input  logic       rx_end,
  input  logic [2:0] rx_ftype,
  input  logic       rx_ack_req,
  output logic       accept
);

  logic type_ok;

  always_comb begin
    type_ok = (rx_ftype == FT_DATA) || (rx_ftype == FT_CMD);
    accept  = rx_end && rx_ack_req && type_ok;
  end

endmodule

// File: rtl/ackseq_timer.sv
module ackseq_timer #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt;
  logic         running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= len - 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign expired = running && (cnt == '0);

  // R3: a new interval is only launched while no interval is in flight
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running);

endmodule

// File: rtl/slotted_ack_seq.sv
module slotted_ack_seq
  import ackseq_pkg::*;
#(
  parameter int CLK_MHZ       = 16,
  parameter int SYMBOL_US     = 16,
  parameter int READY_SYMBOLS = 6,
  parameter int TRIG_DELAY_US = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slotted_en,
  input  logic       rx_end,
  input  logic [2:0] rx_ftype,
  input  logic       rx_ack_req,
  input  logic       host_trig,
  output logic [2:0] ack_status,
  output logic       ack_tx_start
);

  localparam int READY_CYC = READY_SYMBOLS * SYMBOL_US * CLK_MHZ;
  localparam int TRIG_CYC  = TRIG_DELAY_US * CLK_MHZ;
  localparam int MAX_CYC   = (READY_CYC > TRIG_CYC) ? READY_CYC : TRIG_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] READY_LEN = CNT_W'(READY_CYC);
  localparam logic [CNT_W-1:0] TRIG_LEN  = CNT_W'(TRIG_CYC);

  seq_state_e       state;
  logic             slot_q;
  logic             accept;
  logic             tmr_start;
  logic [CNT_W-1:0] tmr_len;
  logic             tmr_done;

  ackseq_qualify u_qual (
    .rx_end     (rx_end),
    .rx_ftype   (rx_ftype),
    .rx_ack_req (rx_ack_req),
    .accept     (accept)
  );

  always_comb begin
    tmr_start = ((state == S_IDLE) && accept) || ((state == S_WAIT) && host_trig);
    tmr_len   = (state == S_WAIT) ? TRIG_LEN : READY_LEN;
  end

  ackseq_timer #(.W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .len     (tmr_len),
    .expired (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      slot_q       <= 1'b0;
      ack_status   <= ST_NONE;
      ack_tx_start <= 1'b0;
    end else begin
      ack_tx_start <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          state  <= S_TURN;
          slot_q <= slotted_en;
        end
        S_TURN: if (tmr_done) begin
          if (slot_q) begin
            state      <= S_WAIT;
            ack_status <= ST_SUCC_WAIT;
          end else begin
            state        <= S_IDLE;
            ack_status   <= ST_SUCCESS;
            ack_tx_start <= 1'b1;
          end
        end
        S_WAIT: if (host_trig) state <= S_DELAY;
        S_DELAY: if (tmr_done) begin
          state        <= S_IDLE;
          ack_status   <= ST_SUCCESS;
          ack_tx_start <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: strobe is a single-cycle pulse
  a_r5_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ack_tx_start |=> !ack_tx_start);

  // R6: strobe always accompanied by plain success and idle
  a_r6_strobe_success: assert property (@(posedge clk) disable iff (!rst_n)
    ack_tx_start |-> (ack_status == ST_SUCCESS && state == S_IDLE));

  // R3: waiting state is always host-visible
  a_r3_wait_status: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> (ack_status == ST_SUCC_WAIT));

  // R4: without a trigger the wait persists and nothing is sent
  a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !host_trig) |=> (state == S_WAIT && !ack_tx_start));

  // R7: a trigger while idle never leaves idle
  a_r7_idle_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !accept) |=> (state == S_IDLE && !ack_tx_start));

  // R8: unslotted turnaround never shows the waiting code
  a_r8_no_wait_code: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TURN && !slot_q) |=> (ack_status != ST_SUCC_WAIT));

endmodule

// File: tb/tb_slotted_ack_seq.sv
module tb_slotted_ack_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ   = 16;
  localparam int READY = 6 * 16 * MHZ;
  localparam int TRIG  = 16 * MHZ;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slotted_en = 1'b0, rx_end = 1'b0, rx_ack_req = 1'b0, host_trig = 1'b0;
  logic [2:0] rx_ftype = 3'd0;
  logic [2:0] ack_status;
  logic       ack_tx_start;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slotted_ack_seq dut (
    .clk(clk), .rst_n(rst_n), .slotted_en(slotted_en), .rx_end(rx_end),
    .rx_ftype(rx_ftype), .rx_ack_req(rx_ack_req), .host_trig(host_trig),
    .ack_status(ack_status), .ack_tx_start(ack_tx_start));

  // vector: {slotted, ftype[2:0], ack_req, expect[1:0]}; expect 0 none, 1 wait, 2 auto
  localparam logic [6:0] VEC [7] = '{
    {1'b1, 3'd1, 1'b1, 2'd1},
    {1'b1, 3'd3, 1'b1, 2'd1},
    {1'b1, 3'd1, 1'b0, 2'd0},
    {1'b1, 3'd0, 1'b1, 2'd0},
    {1'b1, 3'd2, 1'b1, 2'd0},
    {1'b0, 3'd1, 1'b1, 2'd2},
    {1'b0, 3'd3, 1'b1, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_end(input logic slot, input logic [2:0] ft, input logic req);
    slotted_en = slot; rx_ftype = ft; rx_ack_req = req; rx_end = 1'b1;
    @(negedge clk);
    rx_end = 1'b0; rx_ack_req = 1'b0; rx_ftype = 3'd0;
  endtask

  task automatic pulse_trig();
    host_trig = 1'b1;
    @(negedge clk);
    host_trig = 1'b0;
  endtask

  task automatic trig_and_check(input string tag);
    pulse_trig();
    repeat (TRIG - 1) @(negedge clk);
    chk(ack_tx_start == 1'b0, {tag, " R5 early strobe"}, ack_tx_start, 0);
    @(negedge clk);
    chk(ack_tx_start == 1'b1, {tag, " R5 strobe after delay"}, ack_tx_start, 1);
    chk(ack_status == 3'd1, {tag, " R6 success code"}, ack_status, 1);
    @(negedge clk);
    chk(ack_tx_start == 1'b0, {tag, " R5 strobe width"}, ack_tx_start, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] prev;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ack_status == 3'd0, "R1 status", ack_status, 0);
    chk(ack_tx_start == 1'b0, "R1 strobe", ack_tx_start, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      prev = ack_status;
      send_end(VEC[i][6], VEC[i][5:3], VEC[i][2]);
      repeat (READY - 1) @(negedge clk);
      chk(ack_tx_start == 1'b0 && ack_status != 3'd2, "R3 before turnaround", ack_status, prev);
      @(negedge clk);
      case (VEC[i][1:0])
        2'd1: begin
          chk(ack_status == 3'd2, "R3 wait code at turnaround", ack_status, 2);
          repeat (40) @(negedge clk);
          chk(ack_status == 3'd2 && !ack_tx_start, "R4 holds without trigger", ack_status, 2);
          trig_and_check("vec");
        end
        2'd2: begin
          chk(ack_tx_start == 1'b1, "R8 auto strobe", ack_tx_start, 1);
          chk(ack_status == 3'd1, "R8 success code", ack_status, 1);
          @(negedge clk);
          chk(ack_tx_start == 1'b0, "R8 strobe width", ack_tx_start, 0);
        end
        default: begin
          chk(ack_tx_start == 1'b0, "R2 unqualified frame no strobe", ack_tx_start, 0);
          chk(ack_status == prev, "R2 status unchanged", ack_status, prev);
        end
      endcase
      repeat (5) @(negedge clk);
    end

    // R7: trigger while idle
    prev = ack_status;
    pulse_trig();
    repeat (TRIG + 3) @(negedge clk);
    chk(ack_tx_start == 1'b0 && ack_status == prev, "R7 idle trigger ignored", ack_status, prev);

    // R7: early trigger during turnaround; R9: second end pulse mid-sequence
    send_end(1'b1, 3'd1, 1'b1);
    repeat (100) @(negedge clk);
    pulse_trig();
    repeat (READY - 102) @(negedge clk);
    chk(ack_status == 3'd1 && !ack_tx_start, "R7 early trigger no effect", ack_status, 1);
    @(negedge clk);
    chk(ack_status == 3'd2, "R7 wait still reached", ack_status, 2);
    send_end(1'b0, 3'd3, 1'b1);
    repeat (READY + 5) @(negedge clk);
    chk(ack_status == 3'd2 && !ack_tx_start, "R9 second end pulse ignored", ack_status, 2);
    trig_and_check("R9");

    // R9: mode sampled at end pulse, slotted_en dropped during turnaround
    send_end(1'b1, 3'd1, 1'b1);
    slotted_en = 1'b0;
    repeat (READY - 1) @(negedge clk);
    @(negedge clk);
    chk(ack_status == 3'd2 && !ack_tx_start, "R9 mode latched at frame end", ack_status, 2);

    // R1: reset during wait clears status
    rst_n = 1'b0;
    @(negedge clk);
    chk(ack_status == 3'd0 && !ack_tx_start, "R1 reset mid-wait", ack_status, 0);
    rst_n = 1'b1;
    pulse_trig();
    repeat (TRIG + 3) @(negedge clk);
    chk(ack_tx_start == 1'b0 && ack_status == 3'd0, "R7 trigger after reset ignored", ack_status, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule